// File: doc/BRIEF.md
# Pixel Group Bus Selector

This block is a digital model of a two-phase pixel-group selector for a small imaging array. It keeps a 16 by 16 frame of unsigned pixel values and a second frame that holds the image as it stood before the most recent frame-advance strobe. Six 16-bit scan registers decide which pixels are added onto eight output buses. The buses are three horizontal-group sums, three vertical-group sums, one sum of the current frame over a small "centre" group, and the same centre group taken from the previous frame.

Selection happens in two phases. In phase one, a column mask sums each row over the masked columns, which gives one sum per row. A row mask does the same for columns, which gives one sum per column. In phase two, a pair of registers supplies a 2-bit steering code for every row, and that code adds the row sum onto one of the three horizontal buses or onto none. A second pair does the same for column sums onto the vertical buses. When both bits of a row's pair and both bits of a column's pair are set, the NAND of each pair is low and enables that pixel. The enabled pixels form the group summed onto the current-frame and previous-frame buses.

Downstream weighting logic uses the block by loading pixels and scan patterns, then pulsing a compute strobe. All eight sums appear together, registered, one cycle later.

Top module: `pixgrp_bus_sel`

## Requirements
- R1: After synchronous reset, all eight bus outputs are zero, `out_valid` is low, both frames are all zero and every scan register is zero.
- R2: A pixel write with `pix_we` high stores `pix_data` at row `pix_row`, column `pix_col` of the current frame. Rows and columns are numbered from 0.
- R3: Phase one, horizontal: the sum for row r adds the current-frame pixels (r,c) whose column-mask bit c is 1. The column mask is scan select 0.
- R4: Phase one, vertical: the sum for column c adds the current-frame pixels (r,c) whose row-mask bit r is 1. The row mask is scan select 1.
- R5: Phase two steering: for row r, the code is {select 3 bit r, select 2 bit r}. For column c, the code is {select 5 bit c, select 4 bit c}. Code 00 adds the line to no bus, 01 adds it to bus 1, 11 to bus 2 and 10 to bus 3. Each bus is the sum of all lines steered to it.
- R6: The centre-group bus adds every current-frame pixel (r,c) whose row code is 11 and whose column code is 11. This group does not depend on either mask.
- R7: The previous-frame bus adds the previous-frame pixels of the same group as R6.
- R8: A frame-advance strobe copies the whole current frame into the previous frame. A pixel write in the same cycle lands only in the current frame, and the previous frame is unchanged in cycles without the strobe.
- R9: A compute strobe captures all eight sums in the next clock edge. `out_valid` is high for exactly the cycle after each strobe, and the bus outputs hold their values when no strobe is given.
- R10: A scan write with `scan_we` high loads `scan_data` into the register chosen by `scan_sel` (0 to 5). Select values 6 and 7 change no register.
- R11: With column mask and row mask both 0x0005, row and column codes 01, 11 and 10 for indices 0, 1 and 2, and 00 elsewhere, the buses carry X1=P(0,0)+P(0,2), X2=P(1,0)+P(1,2), X3=P(2,0)+P(2,2), Y1=P(0,0)+P(2,0), Y2=P(0,1)+P(2,1), Y3=P(0,2)+P(2,2), centre=P(1,1) and previous=P(1,1) of the earlier frame.
- R12: Bus sums are SUM_W bits wide, 16 by default, and do not overflow even when all 256 pixels are 255 and all land on one bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_we | input | 1 | Pixel write enable |
| pix_row | input | 4 | Pixel write row |
| pix_col | input | 4 | Pixel write column |
| pix_data | input | 8 | Pixel write value |
| frame_adv | input | 1 | Copy current frame into previous frame |
| scan_we | input | 1 | Scan register write enable |
| scan_sel | input | 3 | Scan register select (0 col mask, 1 row mask, 2/3 row code low/high, 4/5 column code low/high) |
| scan_data | input | 16 | Scan register write value |
| calc | input | 1 | Compute strobe |
| out_valid | output | 1 | High the cycle after a compute strobe |
| bus_x1 | output | 16 | Horizontal bus 1 |
| bus_x2 | output | 16 | Horizontal bus 2 |
| bus_x3 | output | 16 | Horizontal bus 3 |
| bus_y1 | output | 16 | Vertical bus 1 |
| bus_y2 | output | 16 | Vertical bus 2 |
| bus_y3 | output | 16 | Vertical bus 3 |
| bus_org | output | 16 | Centre group, current frame |
| bus_del | output | 16 | Centre group, previous frame |

## Verification
All eight sums and `out_valid` are due one cycle after a compute strobe, because only one register stage follows the adders. A pixel, scan or frame-advance write made in one cycle is visible to a strobe in the next cycle. The bench drives every input on the falling edge and holds the strobe for one cycle. It then reads the outputs on the following falling edge, half a period after the capturing edge. It checks the falling edge after that to confirm that `out_valid` has dropped. The hold checks wait several cycles without a strobe while stored state changes, and they confirm that the outputs have not moved.

// File: rtl/pixgrp_pkg.sv
package pixgrp_pkg;

  typedef enum logic [2:0] {
    SEL_COL_MASK = 3'd0,
    SEL_ROW_MASK = 3'd1,
    SEL_ROW_LO   = 3'd2,
    SEL_ROW_HI   = 3'd3,
    SEL_COL_LO   = 3'd4,
    SEL_COL_HI   = 3'd5
  } scan_sel_e;

  localparam int NUM_LINES = 3;

  // Steering code to one-hot bus pick: 01 -> bus1, 11 -> bus2, 10 -> bus3
  function automatic logic [NUM_LINES-1:0] steer_onehot(input logic [1:0] code);
    case (code)
      2'b01:   return 3'b001;
      2'b11:   return 3'b010;
      2'b10:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/pixgrp_frame_store.sv
module pixgrp_frame_store #(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int PIX_W = 8,
  parameter int RAW   = $clog2(ROWS),
  parameter int CAW   = $clog2(COLS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [RAW-1:0]                     wr_row,
  input  logic [CAW-1:0]                     wr_col,
  input  logic [PIX_W-1:0]                   wr_data,
  input  logic                               adv,
  output logic [ROWS*COLS-1:0][PIX_W-1:0]    cur_q,
  output logic [ROWS*COLS-1:0][PIX_W-1:0]    del_q
);

  int wr_idx;

  always_comb begin
    wr_idx = int'(wr_row) * COLS + int'(wr_col);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      del_q <= '0;
    end else begin
      if (adv) begin
        del_q <= cur_q;
      end
      if (wr_en) begin
        cur_q[wr_idx] <= wr_data;
      end
    end
  end

  AST_ADV_COPIES: assert property (@(posedge clk) disable iff (rst)
    adv |=> del_q == $past(cur_q)); // R8

  AST_DEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(del_q)); // R8

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cur_q[$past(wr_idx)] == $past(wr_data)); // R2

endmodule

// File: rtl/pixgrp_scan_regs.sv
module pixgrp_scan_regs
  import pixgrp_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int SCAN_W = (ROWS > COLS) ? ROWS : COLS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [SCAN_W-1:0] data,
  output logic [COLS-1:0]   col_mask,
  output logic [ROWS-1:0]   row_mask,
  output logic [ROWS-1:0]   row_lo,
  output logic [ROWS-1:0]   row_hi,
  output logic [COLS-1:0]   col_lo,
  output logic [COLS-1:0]   col_hi
);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_mask <= '0;
      row_mask <= '0;
      row_lo   <= '0;
      row_hi   <= '0;
      col_lo   <= '0;
      col_hi   <= '0;
    end else if (we) begin
      case (sel)
        SEL_COL_MASK: col_mask <= data[COLS-1:0];
        SEL_ROW_MASK: row_mask <= data[ROWS-1:0];
        SEL_ROW_LO:   row_lo   <= data[ROWS-1:0];
        SEL_ROW_HI:   row_hi   <= data[ROWS-1:0];
        SEL_COL_LO:   col_lo   <= data[COLS-1:0];
        SEL_COL_HI:   col_hi   <= data[COLS-1:0];
        default: ;
      endcase
    end
  end

  AST_SCAN_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable({col_mask, row_mask, row_lo, row_hi, col_lo, col_hi})); // R10

  AST_SCAN_BAD_SEL: assert property (@(posedge clk) disable iff (rst)
    (we && sel > 3'd5) |=> $stable({col_mask, row_mask, row_lo, row_hi, col_lo, col_hi})); // R10

  AST_SCAN_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (we && sel == 3'd0) |=> col_mask == $past(data[COLS-1:0])); // R10

endmodule

// File: rtl/pixgrp_bus_adder.sv
module pixgrp_bus_adder
  import pixgrp_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + $clog2(ROWS * COLS)
) (
  input  logic [ROWS*COLS-1:0][PIX_W-1:0] cur,
  input  logic [ROWS*COLS-1:0][PIX_W-1:0] del,
  input  logic [COLS-1:0]                 col_mask,
  input  logic [ROWS-1:0]                 row_mask,
  input  logic [ROWS-1:0]                 row_lo,
  input  logic [ROWS-1:0]                 row_hi,
  input  logic [COLS-1:0]                 col_lo,
  input  logic [COLS-1:0]                 col_hi,
  output logic [NUM_LINES-1:0][SUM_W-1:0] sum_x,
  output logic [NUM_LINES-1:0][SUM_W-1:0] sum_y,
  output logic [SUM_W-1:0]                sum_org,
  output logic [SUM_W-1:0]                sum_del
);

  // Active-low group enables: NAND of each code pair
  logic [ROWS-1:0] row_en_n;
  logic [COLS-1:0] col_en_n;

  always_comb begin
    row_en_n = ~(row_lo & row_hi);
    col_en_n = ~(col_lo & col_hi);
  end

  // Phase one plus phase two for rows onto horizontal buses
  always_comb begin
    logic [SUM_W-1:0]     acc;
    logic [NUM_LINES-1:0] pick;
    sum_x = '0;
    for (int r = 0; r < ROWS; r++) begin
      acc = '0;
      for (int c = 0; c < COLS; c++) begin
        if (col_mask[c]) acc = acc + SUM_W'(cur[r*COLS+c]);
      end
      pick = steer_onehot({row_hi[r], row_lo[r]});
      for (int k = 0; k < NUM_LINES; k++) begin
        if (pick[k]) sum_x[k] = sum_x[k] + acc;
      end
    end
  end

  // Same for columns onto vertical buses
  always_comb begin
    logic [SUM_W-1:0]     acc;
    logic [NUM_LINES-1:0] pick;
    sum_y = '0;
    for (int c = 0; c < COLS; c++) begin
      acc = '0;
      for (int r = 0; r < ROWS; r++) begin
        if (row_mask[r]) acc = acc + SUM_W'(cur[r*COLS+c]);
      end
      pick = steer_onehot({col_hi[c], col_lo[c]});
      for (int k = 0; k < NUM_LINES; k++) begin
        if (pick[k]) sum_y[k] = sum_y[k] + acc;
      end
    end
  end

  // Centre group on both frames
  always_comb begin
    sum_org = '0;
    sum_del = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (!row_en_n[r] && !col_en_n[c]) begin
          sum_org = sum_org + SUM_W'(cur[r*COLS+c]);
          sum_del = sum_del + SUM_W'(del[r*COLS+c]);
        end
      end
    end
  end

endmodule

// File: rtl/pixgrp_bus_sel.sv
module pixgrp_bus_sel
  import pixgrp_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int PIX_W  = 8,
  parameter int RAW    = $clog2(ROWS),
  parameter int CAW    = $clog2(COLS),
  parameter int SCAN_W = (ROWS > COLS) ? ROWS : COLS,
  parameter int SUM_W  = PIX_W + $clog2(ROWS * COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_we,
  input  logic [RAW-1:0]    pix_row,
  input  logic [CAW-1:0]    pix_col,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              frame_adv,
  input  logic              scan_we,
  input  logic [2:0]        scan_sel,
  input  logic [SCAN_W-1:0] scan_data,
  input  logic              calc,
  output logic              out_valid,
  output logic [SUM_W-1:0]  bus_x1,
  output logic [SUM_W-1:0]  bus_x2,
  output logic [SUM_W-1:0]  bus_x3,
  output logic [SUM_W-1:0]  bus_y1,
  output logic [SUM_W-1:0]  bus_y2,
  output logic [SUM_W-1:0]  bus_y3,
  output logic [SUM_W-1:0]  bus_org,
  output logic [SUM_W-1:0]  bus_del
);

  logic [ROWS*COLS-1:0][PIX_W-1:0] cur_q, del_q;
  logic [COLS-1:0] col_mask, col_lo, col_hi;
  logic [ROWS-1:0] row_mask, row_lo, row_hi;
  logic [NUM_LINES-1:0][SUM_W-1:0] sum_x, sum_y;
  logic [SUM_W-1:0] sum_org, sum_del;

  pixgrp_frame_store #(
    .ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .RAW(RAW), .CAW(CAW)
  ) i_frames (
    .clk(clk), .rst(rst), .wr_en(pix_we), .wr_row(pix_row), .wr_col(pix_col),
    .wr_data(pix_data), .adv(frame_adv), .cur_q(cur_q), .del_q(del_q)
  );

  pixgrp_scan_regs #(
    .ROWS(ROWS), .COLS(COLS), .SCAN_W(SCAN_W)
  ) i_scan (
    .clk(clk), .rst(rst), .we(scan_we), .sel(scan_sel), .data(scan_data),
    .col_mask(col_mask), .row_mask(row_mask), .row_lo(row_lo), .row_hi(row_hi),
    .col_lo(col_lo), .col_hi(col_hi)
  );

  pixgrp_bus_adder #(
    .ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .SUM_W(SUM_W)
  ) i_adder (
    .cur(cur_q), .del(del_q), .col_mask(col_mask), .row_mask(row_mask),
    .row_lo(row_lo), .row_hi(row_hi), .col_lo(col_lo), .col_hi(col_hi),
    .sum_x(sum_x), .sum_y(sum_y), .sum_org(sum_org), .sum_del(sum_del)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      bus_x1 <= '0; bus_x2 <= '0; bus_x3 <= '0;
      bus_y1 <= '0; bus_y2 <= '0; bus_y3 <= '0;
      bus_org <= '0; bus_del <= '0;
    end else begin
      out_valid <= calc;
      if (calc) begin
        bus_x1  <= sum_x[0];
        bus_x2  <= sum_x[1];
        bus_x3  <= sum_x[2];
        bus_y1  <= sum_y[0];
        bus_y2  <= sum_y[1];
        bus_y3  <= sum_y[2];
        bus_org <= sum_org;
        bus_del <= sum_del;
      end
    end
  end

  AST_VALID_AFTER_CALC: assert property (@(posedge clk) disable iff (rst)
    calc |=> out_valid); // R9

  AST_VALID_ONLY_AFTER_CALC: assert property (@(posedge clk) disable iff (rst)
    !calc |=> !out_valid); // R9

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !calc |=> $stable({bus_x1, bus_x2, bus_x3, bus_y1, bus_y2, bus_y3, bus_org, bus_del})); // R9

  AST_ORG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    calc |=> bus_org == $past(sum_org) && bus_del == $past(sum_del)); // R6

endmodule

// File: tb/test_pixgrp_bus_sel.sv
module test_pixgrp_bus_sel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_we = 1'b0;
  logic [3:0]  pix_row = '0;
  logic [3:0]  pix_col = '0;
  logic [7:0]  pix_data = '0;
  logic        frame_adv = 1'b0;
  logic        scan_we = 1'b0;
  logic [2:0]  scan_sel = '0;
  logic [15:0] scan_data = '0;
  logic        calc = 1'b0;
  logic        out_valid;
  logic [15:0] bus_x1, bus_x2, bus_x3, bus_y1, bus_y2, bus_y3, bus_org, bus_del;

  int n_tests = 0;
  int n_fail  = 0;

  int mpix [16][16];
  int mdel [16][16];
  int mscan [6];
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  pixgrp_bus_sel i_pixgrp_bus_sel (
    .clk(clk), .rst(rst), .pix_we(pix_we), .pix_row(pix_row), .pix_col(pix_col),
    .pix_data(pix_data), .frame_adv(frame_adv), .scan_we(scan_we),
    .scan_sel(scan_sel), .scan_data(scan_data), .calc(calc), .out_valid(out_valid),
    .bus_x1(bus_x1), .bus_x2(bus_x2), .bus_x3(bus_x3),
    .bus_y1(bus_y1), .bus_y2(bus_y2), .bus_y3(bus_y3),
    .bus_org(bus_org), .bus_del(bus_del)
  );

  function automatic int unsigned next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic int bus_of(int code);
    // R5: 01 -> 0, 11 -> 1, 10 -> 2, 00 -> none
    if (code == 1) return 0;
    if (code == 3) return 1;
    if (code == 2) return 2;
    return -1;
  endfunction

  function automatic void model(output int ex [8]);
    for (int i = 0; i < 8; i++) ex[i] = 0;
    for (int r = 0; r < 16; r++) begin
      int s = 0;
      int code = (((mscan[3] >> r) & 1) << 1) | ((mscan[2] >> r) & 1);
      for (int c = 0; c < 16; c++) if ((mscan[0] >> c) & 1) s += mpix[r][c];
      if (bus_of(code) >= 0) ex[bus_of(code)] += s;
    end
    for (int c = 0; c < 16; c++) begin
      int s = 0;
      int code = (((mscan[5] >> c) & 1) << 1) | ((mscan[4] >> c) & 1);
      for (int r = 0; r < 16; r++) if ((mscan[1] >> r) & 1) s += mpix[r][c];
      if (bus_of(code) >= 0) ex[3 + bus_of(code)] += s;
    end
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        if (((mscan[2] >> r) & (mscan[3] >> r) & 1) == 1 &&
            ((mscan[4] >> c) & (mscan[5] >> c) & 1) == 1) begin
          ex[6] += mpix[r][c];
          ex[7] += mdel[r][c];
        end
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int act_bus(int i);
    case (i)
      0: return int'(bus_x1);
      1: return int'(bus_x2);
      2: return int'(bus_x3);
      3: return int'(bus_y1);
      4: return int'(bus_y2);
      5: return int'(bus_y3);
      6: return int'(bus_org);
      default: return int'(bus_del);
    endcase
  endfunction

  task automatic check_all(string req, const ref int ex [8]);
    string nm [8] = '{"x1", "x2", "x3", "y1", "y2", "y3", "org", "del"};
    for (int i = 0; i < 8; i++) chk(req, nm[i], act_bus(i), ex[i]);
  endtask

  task automatic wr_pix(int r, int c, int v);
    @(negedge clk);
    pix_we = 1'b1; pix_row = 4'(r); pix_col = 4'(c); pix_data = 8'(v);
    @(negedge clk);
    pix_we = 1'b0;
    mpix[r][c] = v;
  endtask

  task automatic wr_scan(int s, int v);
    @(negedge clk);
    scan_we = 1'b1; scan_sel = 3'(s); scan_data = 16'(v);
    @(negedge clk);
    scan_we = 1'b0;
    if (s < 6) mscan[s] = v & 16'hFFFF;
  endtask

  task automatic advance();
    @(negedge clk);
    frame_adv = 1'b1;
    @(negedge clk);
    frame_adv = 1'b0;
    mdel = mpix;
  endtask

  task automatic run_calc(string req);
    int ex [8];
    @(negedge clk);
    calc = 1'b1;
    @(negedge clk);
    calc = 1'b0;
    chk("R9", "valid after strobe", int'(out_valid), 1);
    model(ex);
    check_all(req, ex);
    @(negedge clk);
    chk("R9", "valid drops", int'(out_valid), 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ex [8];
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin mpix[r][c] = 0; mdel[r][c] = 0; end
    for (int s = 0; s < 6; s++) mscan[s] = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "valid", int'(out_valid), 0);
    for (int i = 0; i < 8; i++) chk("R1", "bus zero", act_bus(i), 0);
    run_calc("R1");

    // R11: reference 3x3 configuration
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) wr_pix(r, c, 10 + r * 30 + c * 7);
    advance();
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) wr_pix(r, c, 5 + r * 11 + c * 40);
    wr_scan(0, 16'h0005);
    wr_scan(1, 16'h0005);
    wr_scan(2, 16'h0003);
    wr_scan(3, 16'h0006);
    wr_scan(4, 16'h0003);
    wr_scan(5, 16'h0006);
    @(negedge clk); calc = 1'b1;
    @(negedge clk); calc = 1'b0;
    chk("R11", "x1", int'(bus_x1), mpix[0][0] + mpix[0][2]);
    chk("R11", "x2", int'(bus_x2), mpix[1][0] + mpix[1][2]);
    chk("R11", "x3", int'(bus_x3), mpix[2][0] + mpix[2][2]);
    chk("R11", "y1", int'(bus_y1), mpix[0][0] + mpix[2][0]);
    chk("R11", "y2", int'(bus_y2), mpix[0][1] + mpix[2][1]);
    chk("R11", "y3", int'(bus_y3), mpix[0][2] + mpix[2][2]);
    chk("R11", "org", int'(bus_org), 5 + 11 + 40);
    chk("R7", "del", int'(bus_del), 10 + 30 + 7);

    // R10: select codes 6 and 7 change nothing
    wr_scan(6, 16'hFFFF);
    wr_scan(7, 16'hFFFF);
    run_calc("R10");

    // R9: outputs hold while state changes without a strobe
    model(ex);
    wr_pix(1, 1, 200);
    wr_scan(0, 16'hFFFF);
    advance();
    repeat (3) @(negedge clk);
    check_all("R9", ex);
    run_calc("R9");

    // R8: advance and write in the same cycle
    @(negedge clk);
    frame_adv = 1'b1; pix_we = 1'b1; pix_row = 4'd1; pix_col = 4'd1; pix_data = 8'd77;
    @(negedge clk);
    frame_adv = 1'b0; pix_we = 1'b0;
    mdel = mpix;
    mpix[1][1] = 77;
    run_calc("R8");
    chk("R8", "del keeps old", int'(bus_del), 200);
    chk("R2", "org new", int'(bus_org), 77);

    // R3 R4 R5 R6 R7 R2: pseudo-random sweep
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < 24; k++)
        wr_pix(int'(next_rand() % 16), int'(next_rand() % 16), int'(next_rand() % 256));
      for (int s = 0; s < 6; s++) wr_scan(s, int'(next_rand() & 16'hFFFF));
      if (it % 4 == 3) advance();
      run_calc("R3 R4 R5 R6 R7 sweep");
    end

    // R12: no overflow at full scale
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) wr_pix(r, c, 255);
    advance();
    wr_scan(0, 16'hFFFF);
    wr_scan(1, 16'hFFFF);
    wr_scan(2, 16'hFFFF);
    wr_scan(3, 16'h0000);
    wr_scan(4, 16'hFFFF);
    wr_scan(5, 16'hFFFF);
    run_calc("R12");
    chk("R12", "x1 full", int'(bus_x1), 65280);
    chk("R12", "y2 full", int'(bus_y2), 65280);
    wr_scan(3, 16'hFFFF);
    run_calc("R12");
    chk("R12", "org full", int'(bus_org), 65280);
    chk("R12", "del full", int'(bus_del), 65280);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule